// File: doc/BRIEF.md
# Gated Frequency Counter with Decade Timebase

This block measures the rate of an already squared, clock-synchronous input. A fixed reference clock (10 MHz by default) feeds a chain of three dividers. The chain yields a display scan tick (2 kHz by default). A phase counter that steps on the scan tick opens a counting window of fixed length. With the default parameters the window is open for 0.1 s inside a 0.2 s measure/update cycle.

While the window is open, each rising edge of the input passes through a two-flop synchronizer and an edge detector. It then drives an input prescaler and a cascade of BCD decade counters. When the window closes, a one-clock strobe copies the count into holding registers. The following clock clears the counters, so the next window starts from zero.

The held result is given as packed BCD digits, together with a saturation flag and a blank flag. The blank flag reports that no input was seen. With a prescale of 100 and a 0.1 s window, the digits read in kHz, so a 1.2 MHz input reads 1200.

Top module: `fcnt_top`

## Requirements
- R1: `scan_tick_o` is a one-clock pulse that repeats every DIV_A*DIV_B*DIV_C clocks (5000 clocks by default, which is 2 kHz from 10 MHz).
- R2: `gate_o` is high from reset release for GATE_SCANS scan periods. After that it reopens every CYCLE_SCANS scan periods and stays open for GATE_SCANS scan periods each time. It always opens in the clock that follows a scan tick.
- R3: `strobe_o` is high for exactly one clock, in the first clock in which `gate_o` is low after being high. It is never high while `gate_o` is high.
- R4: In reset, `digits_o` is zero, `blank_o` is 1 and `overflow_o` is 0. The three held outputs change only in the clock that follows a strobe.
- R5: Suppose `sig_i` is sampled low at one clock edge and high at the next. That rise is counted when `gate_o` is high in the clock that begins one edge after the high sample. The held value is floor(N / IN_DIV), where N is the number of rises counted in the window. The defaults therefore read in kHz.
- R6: Counts and prescaler residue from one window never appear in the result of a later window.
- R7: When the quotient exceeds the largest value that NDIG digits can show, every digit holds 9 and `overflow_o` is 1 for that result.
- R8: `blank_o` is 1 exactly when the held quotient is zero. It stays 1 until a nonzero result or a saturated result is held.
- R9: `digits_o` packs digit k in bits [4k+3:4k], with digit 0 least significant. Each digit is a BCD value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_i | input | 1 | Squared input whose rate is measured |
| digits_o | output | 4*NDIG | Held BCD result, digit 0 in the low nibble |
| overflow_o | output | 1 | Held result saturated |
| blank_o | output | 1 | Held result is zero (input absent) |
| scan_tick_o | output | 1 | Display scan pulse |
| gate_o | output | 1 | Counting window open |
| strobe_o | output | 1 | Result capture pulse |

## Verification
Two events can fall on the same clock: the last rise that counts, in the final clock of the window, and the closing of the window, which is followed at once by the strobe that captures the count. A wrong off-by-one in either the window or the capture would lose or gain exactly that rise. The bench provokes this with a period-2 input, with slow periodic inputs and with random per-clock levels, so that rises land on every phase of the window edge. Each held result is compared against an edge count that the bench derives from the input it drove and from the window it saw on `gate_o`.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
   typedef logic [3:0] bcd_t;
   localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/fcnt_divstage.sv
module fcnt_divstage #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   output logic ce_o
);
   if (DIV < 2) begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign ce_o = ce_i;
   end else begin : g_cnt
      localparam int unsigned W = $clog2(DIV);
      logic [W-1:0] cnt;
      logic         wrap;
      assign wrap = (cnt == W'(DIV - 1));
      assign ce_o = ce_i & wrap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (ce_i) begin
            cnt <= wrap ? '0 : cnt + W'(1);
         end
      end
   end
endmodule

// File: rtl/fcnt_timebase.sv
module fcnt_timebase #(
   parameter int unsigned DIV_A       = 10,
   parameter int unsigned DIV_B       = 100,
   parameter int unsigned DIV_C       = 5,
   parameter int unsigned GATE_SCANS  = 200,
   parameter int unsigned CYCLE_SCANS = 400
) (
   input  logic clk,
   input  logic rst_n,
   output logic scan_tick_o,
   output logic gate_o,
   output logic strobe_o,
   output logic clear_o
);
   localparam int unsigned PW = (CYCLE_SCANS < 2) ? 1 : $clog2(CYCLE_SCANS);

   logic ce_a, ce_b, ce_c;

   fcnt_divstage #(.DIV(DIV_A)) u_div_a (.clk(clk), .rst_n(rst_n), .ce_i(1'b1), .ce_o(ce_a));
   fcnt_divstage #(.DIV(DIV_B)) u_div_b (.clk(clk), .rst_n(rst_n), .ce_i(ce_a), .ce_o(ce_b));
   fcnt_divstage #(.DIV(DIV_C)) u_div_c (.clk(clk), .rst_n(rst_n), .ce_i(ce_b), .ce_o(ce_c));

   logic [PW-1:0] phase;
   logic          gate_q, strobe_q, clear_q;
   logic          last_gate_scan, last_cycle_scan;

   assign last_gate_scan  = (phase == PW'(GATE_SCANS - 1));
   assign last_cycle_scan = (phase == PW'(CYCLE_SCANS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         gate_q   <= 1'b1;
         strobe_q <= 1'b0;
         clear_q  <= 1'b0;
      end else begin
         strobe_q <= ce_c & last_gate_scan;
         clear_q  <= strobe_q;
         if (ce_c) begin
            phase <= last_cycle_scan ? '0 : phase + PW'(1);
            if (last_cycle_scan) begin
               gate_q <= 1'b1;
            end else if (last_gate_scan) begin
               gate_q <= 1'b0;
            end
         end
      end
   end

   assign scan_tick_o = ce_c;
   assign gate_o      = gate_q;
   assign strobe_o    = strobe_q;
   assign clear_o     = clear_q;
endmodule

// File: rtl/fcnt_edge.sv
module fcnt_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);
   logic [SYNC_STAGES:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else begin
         shreg <= {shreg[SYNC_STAGES-1:0], sig_i};
      end
   end

   assign rise_o = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/fcnt_counter.sv
module fcnt_counter
   import fcnt_pkg::*;
#(
   parameter int unsigned NDIG   = 6,
   parameter int unsigned IN_DIV = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              cnt_en_i,
   output logic [4*NDIG-1:0] digits_o,
   output logic              ovf_o
);
   logic pulse;

   if (IN_DIV < 2) begin : g_nopre
      assign pulse = cnt_en_i;
   end else begin : g_pre
      localparam int unsigned PSW = $clog2(IN_DIV);
      logic [PSW-1:0] ps;
      logic           ps_wrap;
      assign ps_wrap = (ps == PSW'(IN_DIV - 1));
      assign pulse   = cnt_en_i & ps_wrap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ps <= '0;
         end else if (clr_i) begin
            ps <= '0;
         end else if (cnt_en_i) begin
            ps <= ps_wrap ? '0 : ps + PSW'(1);
         end
      end
   end

   bcd_t [NDIG-1:0] dig;
   logic [NDIG-1:0] nine;
   logic [NDIG-1:0] carry;
   logic            full;
   logic            ovf_q;

   assign full     = &nine;
   assign carry[0] = pulse & ~full;

   for (genvar g = 0; g < NDIG; g++) begin : g_dec
      assign nine[g] = (dig[g] == BCD_MAX);
      if (g < NDIG - 1) begin : g_link
         assign carry[g+1] = carry[g] & nine[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dig[g] <= '0;
         end else if (clr_i) begin
            dig[g] <= '0;
         end else if (carry[g]) begin
            dig[g] <= nine[g] ? '0 : dig[g] + 4'd1;
         end
      end
      assign digits_o[4*g +: 4] = dig[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (clr_i) begin
         ovf_q <= 1'b0;
      end else if (pulse & full) begin
         ovf_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;
endmodule

// File: rtl/fcnt_top.sv
module fcnt_top #(
   parameter int unsigned DIV_A       = 10,
   parameter int unsigned DIV_B       = 100,
   parameter int unsigned DIV_C       = 5,
   parameter int unsigned GATE_SCANS  = 200,
   parameter int unsigned CYCLE_SCANS = 400,
   parameter int unsigned IN_DIV      = 100,
   parameter int unsigned NDIG        = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_i,
   output logic [4*NDIG-1:0] digits_o,
   output logic              overflow_o,
   output logic              blank_o,
   output logic              scan_tick_o,
   output logic              gate_o,
   output logic              strobe_o
);
   if (GATE_SCANS < 1 || GATE_SCANS >= CYCLE_SCANS) begin : g_bad_window
      $error("fcnt_top: window must be shorter than the cycle and nonzero");
   end
   if (NDIG < 1) begin : g_bad_ndig
      $error("fcnt_top: NDIG must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fcnt_top: SYNC_STAGES must be at least 2");
   end
   if (DIV_A * DIV_B * DIV_C < 2) begin : g_bad_div
      $error("fcnt_top: scan period must be at least two clocks");
   end

   logic clear, rise, cnt_ovf;
   logic [4*NDIG-1:0] cnt_digits;

   fcnt_timebase #(
      .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
      .GATE_SCANS(GATE_SCANS), .CYCLE_SCANS(CYCLE_SCANS)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .scan_tick_o(scan_tick_o),
      .gate_o(gate_o), .strobe_o(strobe_o), .clear_o(clear)
   );

   fcnt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .rise_o(rise)
   );

   fcnt_counter #(.NDIG(NDIG), .IN_DIV(IN_DIV)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(clear),
      .cnt_en_i(rise & gate_o), .digits_o(cnt_digits), .ovf_o(cnt_ovf)
   );

   logic [4*NDIG-1:0] held_q;
   logic              ovf_q, blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         ovf_q   <= 1'b0;
         blank_q <= 1'b1;
      end else if (strobe_o) begin
         held_q  <= cnt_digits;
         ovf_q   <= cnt_ovf;
         blank_q <= ~cnt_ovf & (cnt_digits == '0);
      end
   end

   assign digits_o   = held_q;
   assign overflow_o = ovf_q;
   assign blank_o    = blank_q;
endmodule

// File: rtl/fcnt_top_chk.sv
module fcnt_top_chk
   import fcnt_pkg::*;
#(
   parameter int unsigned NDIG = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4*NDIG-1:0] digits_o,
   input logic              overflow_o,
   input logic              blank_o,
   input logic              scan_tick_o,
   input logic              gate_o,
   input logic              strobe_o
);
   logic [4*NDIG-1:0] all_nines;

   for (genvar g = 0; g < NDIG; g++) begin : g_nib
      assign all_nines[4*g +: 4] = BCD_MAX;
      a_r9_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
         digits_o[4*g +: 4] <= BCD_MAX);
   end

   a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      scan_tick_o |=> !scan_tick_o);

   a_r2_gate_opens_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(scan_tick_o));

   a_r3_strobe_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> (!gate_o && $past(gate_o)));

   a_r3_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe_o) |-> ($stable(digits_o) && $stable(overflow_o) && $stable(blank_o)));

   a_r7_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> (digits_o == all_nines));

   a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> (digits_o == '0 && !overflow_o));
endmodule

bind fcnt_top fcnt_top_chk #(.NDIG(NDIG)) u_chk (
   .clk(clk), .rst_n(rst_n), .digits_o(digits_o), .overflow_o(overflow_o),
   .blank_o(blank_o), .scan_tick_o(scan_tick_o), .gate_o(gate_o), .strobe_o(strobe_o)
);

// File: tb/sim_fcnt_top.sv
`timescale 1ns/1ps
module sim_fcnt_top;
   localparam int unsigned DA = 2, DB = 5, DC = 3;
   localparam int unsigned GS = 16, CS = 32;
   localparam int unsigned IND = 2, ND = 2;
   localparam int SCAN = DA * DB * DC;
   localparam int NMEAS = 45;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sig = 1'b0;
   logic [4*ND-1:0] digits;
   logic ovf, blank, scan, gate, strobe;

   always #2 clk = ~clk;

   fcnt_top #(
      .DIV_A(DA), .DIV_B(DB), .DIV_C(DC), .GATE_SCANS(GS), .CYCLE_SCANS(CS),
      .IN_DIV(IND), .NDIG(ND), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sig_i(sig), .digits_o(digits),
      .overflow_o(ovf), .blank_o(blank), .scan_tick_o(scan),
      .gate_o(gate), .strobe_o(strobe)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [4*ND-1:0] to_bcd(input int unsigned v);
      logic [4*ND-1:0] r;
      int unsigned x;
      x = v;
      r = '0;
      for (int k = 0; k < ND; k++) begin
         r[4*k +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   function automatic int unsigned max_show();
      int unsigned m;
      m = 1;
      for (int k = 0; k < ND; k++) m = m * 10;
      return m - 1;
   endfunction

   // stimulus
   int mode = 0;
   int per = 2;
   int phc = 0;
   always @(posedge clk) begin
      #1;
      case (mode)
         0: sig = 1'b0;
         1: sig = 1'b1;
         2: begin
            phc = (phc + 1) % per;
            sig = (phc < per / 2);
         end
         default: sig = 1'($urandom % 2);
      endcase
   end

   // observation model
   bit b1 = 0, b2 = 0, b3 = 0, b4 = 0;
   int edges = 0, cyc = 0, last_scan = -1, grun = 0, last_grise = 1, nmeas = 0;
   bit prev_gate = 1, prev_strobe = 0, changed = 0, prev_nonzero = 0;
   logic [4*ND-1:0] exp_dig, last_dig;
   bit exp_ovf, exp_blank, last_ovf, last_blank;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         {b4, b3, b2, b1} = {b3, b2, b1, sig};
         if (gate && b3 && !b4) edges++;

         if (scan) begin
            if (last_scan >= 0) check(cyc - last_scan == SCAN, "R1", "scan tick spacing", cyc - last_scan, SCAN);
            last_scan = cyc;
         end

         if (!prev_gate && gate) begin
            check(cyc - last_grise == CS * SCAN, "R2", "window period", cyc - last_grise, CS * SCAN);
            last_grise = cyc;
            grun = 0;
         end
         if (gate) grun++;
         if (prev_gate && !gate) begin
            check(grun == GS * SCAN, "R2", "window length", grun, GS * SCAN);
            check(strobe == 1'b1, "R3", "strobe at close", strobe, 1);
         end
         if (strobe) check(prev_gate && !gate, "R3", "strobe placement", gate, 0);
         if (gate) check(!strobe, "R3", "no strobe in window", strobe, 0);

         if (prev_strobe) begin
            check(digits === exp_dig, prev_nonzero ? "R6" : "R5", "held digits", digits, exp_dig);
            check(digits[3:0] === exp_dig[3:0], "R9", "low digit field", digits[3:0], exp_dig[3:0]);
            check(ovf === exp_ovf, "R7", "overflow flag", ovf, exp_ovf);
            check(blank === exp_blank, "R8", "blank flag", blank, exp_blank);
            check(!changed, "R4", "outputs held between strobes", changed, 0);
            changed = 0;
         end else if (digits !== last_dig || ovf !== last_ovf || blank !== last_blank) begin
            changed = 1;
         end
         last_dig = digits;
         last_ovf = ovf;
         last_blank = blank;

         if (strobe) begin
            int unsigned q;
            q = edges / IND;
            prev_nonzero = (exp_dig != '0) || exp_ovf;
            exp_ovf   = (q > max_show());
            exp_dig   = exp_ovf ? to_bcd(max_show()) : to_bcd(q);
            exp_blank = (q == 0);
            edges = 0;
            nmeas++;
         end
         prev_strobe = strobe;
         prev_gate = gate;
      end
   end

   task automatic report();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", nmeas, NMEAS);
      report();
   end

   initial begin
      void'($urandom(32'd4711));
      exp_dig = '0; last_dig = '0;
      exp_ovf = 0; exp_blank = 1; last_ovf = 0; last_blank = 1;
      repeat (5) @(posedge clk);
      #1;
      check(digits == '0, "R4", "reset digits", digits, 0);
      check(blank == 1'b1, "R4", "reset blank", blank, 1);
      check(ovf == 1'b0, "R4", "reset overflow", ovf, 0);
      check(strobe == 1'b0, "R3", "reset strobe", strobe, 0);
      rst_n = 1'b1;
      for (int i = 0; i < NMEAS; i++) begin
         case (i)
            0: mode = 0;                       // absent input
            1: begin mode = 2; per = 2; end    // saturates (R7)
            2: mode = 1;                       // stuck high after saturation (R6, R8)
            3: begin mode = 2; per = 7; end
            4: begin mode = 2; per = 3; end
            5: mode = 0;
            default: begin
               mode = int'($urandom % 4);
               per = 2 + int'($urandom % 14);
            end
         endcase
         wait (nmeas > i);
      end
      repeat (4) @(posedge clk);
      report();
   end
endmodule